// File: doc/BRIEF.md
# Dual-I/O Lock-Register Command Engine

This block is the slave-side command engine for the per-sector lock bytes of a serial flash. A host talks to it over a chip-select, a serial clock and two bidirectional data lines. Every phase of a command moves two bits per serial clock on both lines: the opcode, a 24-bit address and the lock byte itself. The engine decodes three commands. One arms a write-enable latch. One returns the lock byte of the addressed sector. One stores a new lock byte, and it does so only when the latch is armed.

The serial pins are oversampled in the system clock domain. They pass through a short synchronizer, and the serial clock edges are then found by edge detection. Input pairs are taken on the rising edge of the serial clock. Read data is launched after the falling edge. When the engine is not driving, the two data lines are released through separate output-enable bits. Raising chip-select ends any command. A write only becomes effective if chip-select rises exactly after its last data clock.

Top module: `dspi_lock_engine`

## Requirements
- R1: Bits are counted in serial clocks from the fall of `cs_n`, starting at clock 0. The opcode enters on clocks 0 to 3, most significant pair first. `dq_in[1]` carries the higher bit of each pair. Opcode 0x06 arms the latch, 0xE8 reads a lock byte and 0xE5 writes one.
- R2: The 24-bit address enters on clocks 4 to 15, most significant pair first. Address bits 21 to 16 select one of 64 lock bytes.
- R3: Address bits 23 and 22 have no influence on which lock byte is read or written.
- R4: A read returns the selected lock byte on clocks 16 to 19, bits 7:6 first, with the higher bit of each pair on `dq_out[1]`. Each pair is launched after the falling serial clock edge that precedes its clock.
- R5: `dq_oe` is 2'b11 only during the four data clocks of a read. It is 2'b00 during clocks 0 to 15, after clock 19, and whenever `cs_n` is high, including after a read that is cut short.
- R6: A write stores its byte only when three things hold: the latch is armed, exactly 20 clocks were given, and `cs_n` then rises. That commit disarms the latch, so a second write needs a new arming command.
- R7: A write issued while the latch is not armed leaves every lock byte unchanged.
- R8: A write ended by `cs_n` rising after any clock count other than 20 stores nothing and leaves the latch as it was.
- R9: For an opcode other than the three listed, the engine ignores the rest of the command and never drives the data lines.
- R10: After reset all 64 lock bytes read 0x00 and the latch is disarmed.
- R11: The arming command takes effect only if `cs_n` rises after exactly 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Chip select, active low |
| dq_in | input | 2 | Sampled values of the two data lines |
| dq_out | output | 2 | Values driven onto the data lines during read data clocks |
| dq_oe | output | 2 | Per-line output enable; 0 releases the line to high impedance |

## Verification
Two actions can land in the same system clock cycle. The rising edge of `cs_n` that commits a write also disarms the write-enable latch, so the store and the clear must both see the latch state from before that edge. Another case: chip-select rises while read data is still being driven, and the abort must win over the next data launch. The bench provokes the first with back-to-back writes after a single arming command, and the second with reads truncated at 17 and 18 clocks. It judges both at the ports. A read-back must show that only the first write landed, and `dq_oe` must be released once `cs_n` is high.

// File: rtl/dspi_lock_pkg.sv
// Package: shared constants, command type and opcode decoder for the
// dual-I/O lock-register engine. Assumes 8-bit opcodes.
package dspi_lock_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_ARM     = 8'h06;
    localparam logic [OPC_W-1:0] OPC_LOCK_RD = 8'hE8;
    localparam logic [OPC_W-1:0] OPC_LOCK_WR = 8'hE5;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_ARM,
        CMD_RD,
        CMD_WR
    } cmd_e;

    // Map a received opcode onto a command; anything unknown is CMD_NONE.
    function automatic cmd_e decode_op(input logic [OPC_W-1:0] op);
        case (op)
            OPC_ARM:     return CMD_ARM;
            OPC_LOCK_RD: return CMD_RD;
            OPC_LOCK_WR: return CMD_WR;
            default:     return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dspi_edge_sync.sv
// Module: dspi_edge_sync
// Brings the asynchronous serial pins into the clk domain through STAGES
// flops. It then derives one-cycle pulses for the serial clock edges and for
// the rising edge of chip select. Assumes each serial clock phase lasts
// several clk cycles, so that no edge is missed.
module dspi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic [1:0] dq_in,
    output logic       sck_rise,
    output logic       sck_fall,
    output logic       cs_hi,
    output logic       cs_rise,
    output logic [1:0] dq_s
);

    localparam int          W     = 4;
    localparam logic [W-1:0] RST_V = 4'b0100; // {sck, cs_n, dq}: idle deselected

    logic [W-1:0] stg [STAGES];
    logic [W-1:0] last;
    logic [W-1:0] cur;

    // Synchronizer chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_V;
            last <= RST_V;
        end else begin
            stg[0] <= {sck, cs_n, dq_in};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            last <= stg[STAGES-1];
        end
    end

    // Edge pulses and aligned data from the last two stages.
    always_comb begin
        cur      = stg[STAGES-1];
        sck_rise = cur[3] & ~last[3];
        sck_fall = ~cur[3] & last[3];
        cs_hi    = cur[2];
        cs_rise  = cur[2] & ~last[2];
        dq_s     = cur[1:0];
    end

    AST_ONE_SCK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> !sck_rise) else $error("double rise"); // R1

endmodule

// File: rtl/dspi_lock_file.sv
// Module: dspi_lock_file
// Holds one lock byte per sector. Entries are written on a single-cycle
// strobe and read combinationally by index. Assumes the write index and the
// read index are the same decoded address field.
module dspi_lock_file #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0][DATA_W-1:0] mem;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // One lock byte: cleared by reset, loaded when selected and strobed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[e] <= '0;
            end else if (wr_en && (idx == IDX_W'(e))) begin
                mem[e] <= wr_data;
            end
        end
    end

    // Read port.
    assign rd_data = mem[idx];

    AST_ONLY_STROBE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mem)) else $error("lock byte changed without strobe"); // R7

endmodule

// File: rtl/dspi_lock_seq.sv
// Module: dspi_lock_seq
// Command sequencer. It counts serial clocks since chip select fell and
// shifts in the opcode, address and data pairs. It launches read data after
// falling serial clock edges, keeps the write-enable latch, and produces the
// write strobe when chip select rises. Assumes edge pulses come from
// dspi_edge_sync.
module dspi_lock_seq
    import dspi_lock_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 6,
    parameter int IDX_LSB = 16,
    parameter int CNT_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_hi,
    input  logic              cs_rise,
    input  logic [1:0]        dq_s,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [IDX_W-1:0]  lock_idx,
    output logic [DATA_W-1:0] wr_byte,
    output logic              wr_stb,
    output logic [1:0]        dq_out,
    output logic [1:0]        dq_oe
);

    localparam int OP_CLKS  = OPC_W / 2;
    localparam int ADDR_END = OP_CLKS + ADDR_W / 2;
    localparam int DATA_END = ADDR_END + DATA_W / 2;

    localparam logic [CNT_W-1:0] C_OP  = CNT_W'(OP_CLKS);
    localparam logic [CNT_W-1:0] C_AE  = CNT_W'(ADDR_END);
    localparam logic [CNT_W-1:0] C_DE  = CNT_W'(DATA_END);
    localparam logic [CNT_W-1:0] C_MAX = '1;

    logic [CNT_W-1:0]  cnt;
    logic [OPC_W-1:0]  op_sr;
    logic [ADDR_W-1:0] addr_sr;
    logic [DATA_W-1:0] data_sr;
    logic              wel;
    logic              oe_q;
    cmd_e              cmd;
    logic [CNT_W-1:0]  pair_idx;
    logic [DATA_W-1:0] rd_shift;
    logic              in_data;

    // Clock counter and input shift registers, cleared by deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            op_sr   <= '0;
            addr_sr <= '0;
            data_sr <= '0;
        end else if (cs_hi) begin
            cnt <= '0;
        end else if (sck_rise) begin
            if (cnt < C_OP) begin
                op_sr <= {op_sr[OPC_W-3:0], dq_s};
            end else if (cnt < C_AE) begin
                addr_sr <= {addr_sr[ADDR_W-3:0], dq_s};
            end else if (cnt < C_DE) begin
                data_sr <= {data_sr[DATA_W-3:0], dq_s};
            end
            if (cnt != C_MAX) cnt <= cnt + 1'b1;
        end
    end

    // Command decode once the opcode is complete; pair selection for reads.
    always_comb begin
        cmd      = (cnt >= C_OP) ? decode_op(op_sr) : CMD_NONE;
        pair_idx = cnt - C_AE;
        rd_shift = rd_byte << {pair_idx, 1'b0};
        in_data  = (cmd == CMD_RD) && (cnt >= C_AE) && (cnt < C_DE);
    end

    // Read data launch on falling serial clock; release on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= 1'b0;
            dq_out <= 2'b00;
        end else if (cs_hi) begin
            oe_q   <= 1'b0;
            dq_out <= 2'b00;
        end else if (sck_fall) begin
            oe_q   <= in_data;
            dq_out <= in_data ? rd_shift[DATA_W-1 -: 2] : 2'b00;
        end
    end

    // Write commit: armed latch, exact clock count, chip select rising.
    assign wr_stb = cs_rise && (cmd == CMD_WR) && (cnt == C_DE) && wel;

    // Write-enable latch: armed by an exact arming command, consumed by a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (cs_rise) begin
            if ((cmd == CMD_ARM) && (cnt == C_OP)) begin
                wel <= 1'b1;
            end else if (wr_stb) begin
                wel <= 1'b0;
            end
        end
    end

    assign dq_oe    = {2{oe_q}};
    assign lock_idx = addr_sr[IDX_LSB +: IDX_W];
    assign wr_byte  = data_sr;

    AST_RELEASE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (dq_oe == 2'b00)) else $error("bus held while deselected"); // R5
    AST_DRIVE_IN_DATA_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != 2'b00) |-> (cnt >= C_AE && cnt <= C_DE)) else $error("drive outside data"); // R5
    AST_DRIVE_ONLY_FOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != 2'b00) |-> (cmd == CMD_RD)) else $error("drive for non-read"); // R9
    AST_LATCH_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wel) else $error("latch survived commit"); // R6
    AST_LATCH_ARMS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_rise)) else $error("latch armed mid-command"); // R11
    AST_COUNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_hi && $past(!cs_hi)) |-> (cnt >= $past(cnt))) else $error("count went back"); // R1

endmodule

// File: rtl/dspi_lock_engine.sv
// Module: dspi_lock_engine (top)
// Dual-I/O lock-register command engine. It chains the pin synchronizer, the
// command sequencer and the 64-entry lock byte file. Assumes the serial clock
// phases and chip select high time each last at least STAGES+2 clk cycles.
module dspi_lock_engine #(
    parameter int STAGES  = 2,
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 6,
    parameter int IDX_LSB = 16,
    parameter int CNT_W   = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic [1:0] dq_in,
    output logic [1:0] dq_out,
    output logic [1:0] dq_oe
);

    logic              sck_rise;
    logic              sck_fall;
    logic              cs_hi;
    logic              cs_rise;
    logic [1:0]        dq_s;
    logic [IDX_W-1:0]  lock_idx;
    logic [DATA_W-1:0] wr_byte;
    logic [DATA_W-1:0] rd_byte;
    logic              wr_stb;

    dspi_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .dq_in    (dq_in),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_hi    (cs_hi),
        .cs_rise  (cs_rise),
        .dq_s     (dq_s)
    );

    dspi_lock_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W),
        .IDX_LSB (IDX_LSB),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_hi    (cs_hi),
        .cs_rise  (cs_rise),
        .dq_s     (dq_s),
        .rd_byte  (rd_byte),
        .lock_idx (lock_idx),
        .wr_byte  (wr_byte),
        .wr_stb   (wr_stb),
        .dq_out   (dq_out),
        .dq_oe    (dq_oe)
    );

    dspi_lock_file #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (lock_idx),
        .wr_en   (wr_stb),
        .wr_data (wr_byte),
        .rd_data (rd_byte)
    );

endmodule

// File: tb/dspi_lock_engine_tb.sv
// Bench for dspi_lock_engine: directed corner cases followed by seeded
// random command streams, checked against a bench-side model.
module dspi_lock_engine_tb;

    localparam int H = 6; // clk cycles per serial clock phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic [1:0] dq_in = 2'b00;
    logic [1:0] dq_out;
    logic [1:0] dq_oe;

    int tests = 0;
    int fails = 0;

    logic [7:0] model [64];
    logic       arm_m;

    always #2 clk = ~clk; // 250 MHz

    dspi_lock_engine u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck    (sck),
        .cs_n   (cs_n),
        .dq_in  (dq_in),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int sel(input logic [23:0] adr);
        return int'(adr[21:16]);
    endfunction

    // One chip-select frame of n serial clocks.
    task automatic xfer(input logic [7:0] op, input logic [23:0] adr, input logic [7:0] wd,
                        input int n, output logic [7:0] rd, output int oe_bad, output int oe_data);
        logic [39:0] st;
        st = {op, adr, wd};
        rd = 8'h00; oe_bad = 0; oe_data = 0;
        @(negedge clk); cs_n = 1'b0;
        for (int k = 0; k < n; k++) begin
            dq_in = (k < 20) ? st[39 - 2*k -: 2] : 2'b00;
            repeat (H) @(negedge clk);
            if (dq_oe != 2'b00) begin
                if (k >= 16 && k < 20) begin
                    oe_data++;
                    rd[(19 - k)*2 +: 2] = dq_out;
                end else oe_bad++;
            end
            sck = 1'b1;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
        repeat (H) @(negedge clk);
        if (n >= 20 && dq_oe != 2'b00) oe_bad++;
        cs_n = 1'b1;
        repeat (H) @(negedge clk);
        if (dq_oe != 2'b00) oe_bad++;
        repeat (H) @(negedge clk);
    endtask

    task automatic arm(input int n);
        logic [7:0] r; int b, d;
        xfer(8'h06, 24'h0, 8'h0, n, r, b, d);
        if (n == 4) arm_m = 1'b1;
    endtask

    task automatic wr(input logic [23:0] adr, input logic [7:0] wd, input int n);
        logic [7:0] r; int b, d;
        xfer(8'hE5, adr, wd, n, r, b, d);
        check(b == 0 && d == 0, "R5 no drive on write", b + d, 0);
        if (n == 20 && arm_m) begin
            model[sel(adr)] = wd;
            arm_m = 1'b0;
        end
    endtask

    task automatic rd_chk(input logic [23:0] adr, input string req);
        logic [7:0] r; int b, d;
        xfer(8'hE8, adr, 8'h0, 20, r, b, d);
        check(r == model[sel(adr)], req, r, model[sel(adr)]);
        check(b == 0 && d == 4, "R5 read drive window", b * 16 + d, 4);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] r; int b, d;
        logic [23:0] a;
        void'($urandom(32'd7341));
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        arm_m = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10: reset state
        check(dq_oe == 2'b00, "R10 released after reset", dq_oe, 0);
        rd_chk(24'h000000, "R10 entry 0 zero");
        rd_chk(24'h3F0000, "R10 entry 63 zero");

        // R7: write without arming
        wr(24'h050000, 8'hA5, 20);
        rd_chk(24'h050000, "R7 unarmed write refused");

        // R2 R3 R6: armed write with top bits set, read back with other top bits
        arm(4);
        wr(24'hC51234, 8'h96, 20);
        rd_chk(24'h050000, "R3 top bits ignored on write");
        rd_chk(24'h85FFFF, "R2 R4 read via A21..A16");
        // R6: latch consumed, second write refused
        wr(24'h050000, 8'h11, 20);
        rd_chk(24'h450000, "R6 second write needs rearm");

        // R8: truncated and overlong writes discarded, latch kept
        arm(4);
        wr(24'h0A0000, 8'h3C, 19);
        wr(24'h0A0000, 8'h3C, 21);
        rd_chk(24'h0A0000, "R8 wrong count discards write");
        wr(24'h0A0000, 8'hC3, 20);
        rd_chk(24'h0A0000, "R8 latch kept after abort");

        // R11: arming with extra clock ignored
        arm(5);
        wr(24'h0B0000, 8'h77, 20);
        rd_chk(24'h0B0000, "R11 inexact arm ignored");

        // R9: unknown opcode never drives
        xfer(8'h9F, 24'h0A0000, 8'h00, 24, r, b, d);
        check(b == 0 && d == 0, "R9 unknown opcode silent", b + d, 0);

        // R5 R1: read aborted mid data releases bus
        xfer(8'hE8, 24'h0A0000, 8'h00, 18, r, b, d);
        check(b == 0 && d == 2 && r[7:4] == 4'hC, "R5 aborted read released", {r, 8'(d)}, 16'hC002);
        xfer(8'hE8, 24'h0A0000, 8'h00, 17, r, b, d);
        check(b == 0 && d == 1, "R1 R5 abort at 17 clocks", b * 16 + d, 1);

        // Random mix
        for (int it = 0; it < 160; it++) begin
            int kind;
            kind = int'($urandom_range(0, 5));
            a = 24'($urandom());
            case (kind)
                0: arm(($urandom_range(0, 5) == 0) ? 5 : 4);
                1, 2: wr(a, 8'($urandom()), ($urandom_range(0, 4) == 0) ? int'($urandom_range(18, 22)) : 20);
                3, 4: rd_chk(a, "R2 R4 random read");
                default: begin
                    logic [7:0] op;
                    op = 8'($urandom());
                    if (op == 8'h06 || op == 8'hE8 || op == 8'hE5) op = 8'h00;
                    xfer(op, a, 8'($urandom()), 20, r, b, d);
                    check(b == 0 && d == 0, "R9 random unknown opcode", b + d, 0);
                end
            endcase
        end
        for (int i = 0; i < 64; i++) rd_chk({2'b10, 6'(i), 16'h0}, "R6 R7 final sweep");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule